// File: doc/BRIEF.md
# Masked Vector Lane Shuffle Unit

This datapath block assembles a 512-bit vector result out of whole 128-bit lanes taken from two source vectors. An 8-bit selector immediate names the source lane for each destination lane. The lower half of the active result always comes from the first source and the upper half always comes from the second source. The block treats every operand as raw bits, so integer and floating-point shuffles share the same hardware.

Before lane selection, the second source can be replaced by copies of its lowest 32-bit or 64-bit element. This models a broadcast memory operand. After the lane crossbar, a per-element write mask either keeps the old destination element (merging) or clears it (zeroing). Mask granularity is 32 or 64 bits. Two operating lengths are supported, 256-bit and 512-bit. Any other length request raises an illegal-length flag instead of producing a result.

The result is registered. A request presented with `in_valid` produces `out_valid` on the following clock.

Top module: `lshuf_unit`

## Requirements
- R1: With `len_mode`=2'b10 (512-bit), destination lane d (bits [128d+127:128d]) is source lane n = `sel_imm`[2d+1:2d], meaning bits [128n+127:128n]. Lanes 0 and 1 are taken from `src1`; lanes 2 and 3 are taken from the second source.
- R2: With `len_mode`=2'b01 (256-bit), destination lane 0 is lane `sel_imm`[0] of `src1`, and destination lane 1 is lane `sel_imm`[1] of the second source. Immediate bits 7..2 have no effect.
- R3: When both `bcast_en` and `src2_mem` are 1, every 32-bit word of the second source is replaced before selection. With `elem64`=0 it becomes `src2`[31:0]; with `elem64`=1 every 64-bit element becomes `src2`[63:0]. If either control is 0, `src2` is used unchanged.
- R4: With `elem64`=0, `mask`[j] governs result bits [32j+31:32j]. With `elem64`=1, `mask`[j] governs bits [64j+63:64j].
- R5: When `mask_en`=1 and an element's mask bit is 0, the element takes its value from `old_dst` if `zero_mode`=0, or becomes zero if `zero_mode`=1. When `mask_en`=0, every active element is written.
- R6: In 256-bit mode, result bits [511:256] are zero regardless of mask, mode or old value.
- R7: A request with `len_mode` 2'b00 or 2'b11 sets `bad_len` on the next clock. In that clock `out_valid` stays 0 and `result` keeps its previous value.
- R8: `out_valid` is 1 exactly one clock after a legal request and 0 after a cycle without a request. Reset clears `out_valid`, `bad_len` and `result`.
- R9: Mask bits above the element count of the active length have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| len_mode | input | 2 | Operating length: 01 = 256-bit, 10 = 512-bit, others illegal |
| elem64 | input | 1 | Element width: 1 = 64-bit, 0 = 32-bit |
| bcast_en | input | 1 | Broadcast request |
| src2_mem | input | 1 | Second source is a memory operand |
| mask_en | input | 1 | Apply write mask |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging for masked-off elements |
| sel_imm | input | 8 | Lane selector immediate |
| mask | input | 16 | Per-element write mask |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| old_dst | input | 512 | Previous destination value for merging |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Registered result |
| bad_len | output | 1 | Illegal-length flag |

## Verification
The clocked assertions check the following on every cycle:
- the handshake timing;
- the illegal-length response and result hold;
- the zeroed upper half in 256-bit mode;
- an all-zero result for a fully cleared zeroing mask;
- the uniform upper half under a 32-bit broadcast.

The actual lane routing for each selector value, the mask granularity, merge values and ignored mask bits are shown only by the bench's scenarios. Those scenarios compare every output against a behavioural model, both for directed immediates and masks and for a random sweep.

// File: rtl/lshuf_pkg.sv
package lshuf_pkg;
  typedef enum logic [1:0] {
    LEN_128 = 2'b00,
    LEN_256 = 2'b01,
    LEN_512 = 2'b10,
    LEN_RSV = 2'b11
  } len_e;

  localparam int VEC_W  = 512;
  localparam int LANE_W = 128;
  localparam int ELEM_W = 32;
  localparam int IMM_W  = 8;
  localparam int MASK_W = 16;
endpackage

// File: rtl/lshuf_bcast.sv
module lshuf_bcast #(
  parameter int VEC_W  = 512,
  parameter int ELEM_W = 32
) (
  input  logic [VEC_W-1:0] src,
  input  logic             bc_on,
  input  logic             wide,
  output logic [VEC_W-1:0] dst
);
  localparam int NWORD = VEC_W / ELEM_W;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic [ELEM_W-1:0] rep;
    assign rep = wide ? src[(w % 2)*ELEM_W +: ELEM_W] : src[ELEM_W-1:0];
    assign dst[w*ELEM_W +: ELEM_W] = bc_on ? rep : src[w*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/lshuf_xbar.sv
module lshuf_xbar #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 128,
  parameter int IMM_W  = 8
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             full,
  output logic [VEC_W-1:0] dst
);
  localparam int NLANE  = VEC_W / LANE_W;
  localparam int SEL_W  = $clog2(NLANE);
  localparam int HSEL_W = SEL_W - 1;

  for (genvar d = 0; d < NLANE; d++) begin : g_lane
    localparam bit FULL_A = (d < NLANE/2);
    localparam bit HALF_A = (d < NLANE/4);
    localparam bit HALF_ON = (d < NLANE/2);
    logic [SEL_W-1:0]  fsel;
    logic [HSEL_W-1:0] hsel;
    logic [VEC_W-1:0]  fsrc;
    logic [VEC_W-1:0]  hsrc;
    logic [LANE_W-1:0] fval;
    logic [LANE_W-1:0] hval;

    assign fsel = imm[d*SEL_W +: SEL_W];
    assign hsel = imm[d*HSEL_W +: HSEL_W];
    assign fsrc = FULL_A ? src_a : src_b;
    assign hsrc = HALF_A ? src_a : src_b;

    always_comb begin
      fval = fsrc[fsel*LANE_W +: LANE_W];
      hval = HALF_ON ? hsrc[{1'b0, hsel}*LANE_W +: LANE_W] : '0;
    end

    assign dst[d*LANE_W +: LANE_W] = full ? fval : hval;
  end
endmodule

// File: rtl/lshuf_mask.sv
module lshuf_mask #(
  parameter int VEC_W  = 512,
  parameter int ELEM_W = 32,
  parameter int MASK_W = 16
) (
  input  logic [VEC_W-1:0]  shuf,
  input  logic [VEC_W-1:0]  old,
  input  logic [MASK_W-1:0] mask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic              wide,
  input  logic              full,
  output logic [VEC_W-1:0]  dst
);
  localparam int NWORD = VEC_W / ELEM_W;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam bit LOW_HALF = (w < NWORD/2);
    logic active;
    logic mbit;
    logic [ELEM_W-1:0] val;

    assign active = full || LOW_HALF;
    assign mbit   = wide ? mask[w/2] : mask[w];

    always_comb begin
      if (!active)
        val = '0;
      else if (!mask_en || mbit)
        val = shuf[w*ELEM_W +: ELEM_W];
      else if (zero_mode)
        val = '0;
      else
        val = old[w*ELEM_W +: ELEM_W];
    end

    assign dst[w*ELEM_W +: ELEM_W] = val;
  end
endmodule

// File: rtl/lshuf_unit.sv
module lshuf_unit
  import lshuf_pkg::*;
#(
  parameter int P_VEC_W  = VEC_W,
  parameter int P_LANE_W = LANE_W,
  parameter int P_ELEM_W = ELEM_W,
  parameter int P_IMM_W  = IMM_W,
  parameter int P_MASK_W = MASK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          len_mode,
  input  logic                elem64,
  input  logic                bcast_en,
  input  logic                src2_mem,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic [P_IMM_W-1:0]  sel_imm,
  input  logic [P_MASK_W-1:0] mask,
  input  logic [P_VEC_W-1:0]  src1,
  input  logic [P_VEC_W-1:0]  src2,
  input  logic [P_VEC_W-1:0]  old_dst,
  output logic                out_valid,
  output logic [P_VEC_W-1:0]  result,
  output logic                bad_len
);
  localparam int HALF_W = P_VEC_W / 2;
  localparam int NQ     = HALF_W / P_ELEM_W;

  logic               full_len;
  logic               legal;
  logic               bc_on;
  logic [P_VEC_W-1:0] src2_x;
  logic [P_VEC_W-1:0] shuf;
  logic [P_VEC_W-1:0] masked;
  logic               nxt_valid;
  logic               nxt_bad;
  logic               res_en;

  assign full_len = (len_mode == LEN_512);
  assign legal    = (len_mode == LEN_512) || (len_mode == LEN_256);
  assign bc_on    = bcast_en && src2_mem;

  lshuf_bcast #(.VEC_W(P_VEC_W), .ELEM_W(P_ELEM_W)) u_bcast (
    .src(src2), .bc_on(bc_on), .wide(elem64), .dst(src2_x)
  );

  lshuf_xbar #(.VEC_W(P_VEC_W), .LANE_W(P_LANE_W), .IMM_W(P_IMM_W)) u_xbar (
    .src_a(src1), .src_b(src2_x), .imm(sel_imm), .full(full_len), .dst(shuf)
  );

  lshuf_mask #(.VEC_W(P_VEC_W), .ELEM_W(P_ELEM_W), .MASK_W(P_MASK_W)) u_mask (
    .shuf(shuf), .old(old_dst), .mask(mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .wide(elem64), .full(full_len), .dst(masked)
  );

  // next-state
  always_comb begin
    nxt_valid = in_valid && legal;
    nxt_bad   = in_valid && !legal;
    res_en    = in_valid && legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bad_len   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= nxt_valid;
      bad_len   <= nxt_bad;
      if (res_en)
        result <= masked;
    end
  end

  // R8: strobe follows a legal request by one clock, drops otherwise
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (len_mode == LEN_256 || len_mode == LEN_512) |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !bad_len);

  // R7: illegal length flags, no strobe, result held
  a_r7_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (len_mode == LEN_128 || len_mode == LEN_RSV) |=> bad_len && !out_valid);
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (len_mode == LEN_128 || len_mode == LEN_RSV) |=> $stable(result));

  // R6: upper half zero at 256-bit length
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(len_mode) == LEN_256 |-> result[P_VEC_W-1:HALF_W] == '0);

  // R5: zeroing with an all-clear mask yields zero
  a_r5_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mask_en && zero_mode && mask == '0) |-> result == '0);

  // R3: 32-bit broadcast makes the upper half uniform
  a_r3_bcast_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(bcast_en && src2_mem && !elem64 && !mask_en && len_mode == LEN_512)
    |-> result[P_VEC_W-1:HALF_W] == {NQ{result[HALF_W +: P_ELEM_W]}});
endmodule

// File: tb/lshuf_unit_bench.sv
`timescale 1ns/1ps
module lshuf_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   len_mode;
  logic         elem64, bcast_en, src2_mem, mask_en, zero_mode;
  logic [7:0]   sel_imm;
  logic [15:0]  mask;
  logic [511:0] src1, src2, old_dst;
  logic         out_valid, bad_len;
  logic [511:0] result;

  int checks = 0;
  int failures = 0;
  logic [511:0] exp_res;

  always #2.5 clk = ~clk;

  lshuf_unit u_lshuf_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .len_mode(len_mode),
    .elem64(elem64), .bcast_en(bcast_en), .src2_mem(src2_mem),
    .mask_en(mask_en), .zero_mode(zero_mode), .sel_imm(sel_imm), .mask(mask),
    .src1(src1), .src2(src2), .old_dst(old_dst),
    .out_valid(out_valid), .result(result), .bad_len(bad_len)
  );

  function automatic logic [511:0] mkvec(input logic [15:0] tag);
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[32*k +: 32] = {tag, 16'(k * 16'h0101 + 16'h0a00)};
    return v;
  endfunction

  function automatic logic [511:0] model(
      input logic [1:0] ln, input logic e64, input logic bc, input logic mem,
      input logic men, input logic zm, input logic [7:0] im, input logic [15:0] m,
      input logic [511:0] a, input logic [511:0] b, input logic [511:0] od);
    logic [511:0] bb, t, r;
    int nw, bit_ix;
    bb = b;
    if (bc && mem)
      for (int k = 0; k < 16; k++)
        bb[32*k +: 32] = e64 ? b[(k % 2)*32 +: 32] : b[31:0];
    t = '0;
    if (ln == 2'b10) begin
      t[0   +: 128] = a[int'(im[1:0])*128 +: 128];
      t[128 +: 128] = a[int'(im[3:2])*128 +: 128];
      t[256 +: 128] = bb[int'(im[5:4])*128 +: 128];
      t[384 +: 128] = bb[int'(im[7:6])*128 +: 128];
      nw = 16;
    end else begin
      t[0   +: 128] = a[int'(im[0])*128 +: 128];
      t[128 +: 128] = bb[int'(im[1])*128 +: 128];
      nw = 8;
    end
    r = '0;
    for (int k = 0; k < 16; k++) begin
      bit_ix = e64 ? k / 2 : k;
      if (k >= nw) r[32*k +: 32] = '0;
      else if (!men || m[bit_ix]) r[32*k +: 32] = t[32*k +: 32];
      else if (zm) r[32*k +: 32] = '0;
      else r[32*k +: 32] = od[32*k +: 32];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] ln, input logic e64,
      input logic bc, input logic mem, input logic men, input logic zm,
      input logic [7:0] im, input logic [15:0] m,
      input logic [511:0] a, input logic [511:0] b, input logic [511:0] od);
    logic lg;
    @(negedge clk);
    in_valid = 1'b1; len_mode = ln; elem64 = e64; bcast_en = bc; src2_mem = mem;
    mask_en = men; zero_mode = zm; sel_imm = im; mask = m;
    src1 = a; src2 = b; old_dst = od;
    lg = (ln == 2'b01) || (ln == 2'b10);
    if (lg) exp_res = model(ln, e64, bc, mem, men, zm, im, m, a, b, od);
    @(posedge clk); #1;
    chk({req, " out_valid"}, 512'(out_valid), 512'(lg));
    chk({req, " bad_len"}, 512'(bad_len), 512'(!lg));
    chk({req, " result"}, result, exp_res);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk({req, " idle out_valid"}, 512'(out_valid), 512'(0));
    chk({req, " idle bad_len"}, 512'(bad_len), 512'(0));
    chk({req, " idle result"}, result, exp_res);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [511:0] A, B, O;
    A = mkvec(16'h1111); B = mkvec(16'h2222); O = mkvec(16'h3333);
    rst_n = 1'b0; in_valid = 1'b0; len_mode = 2'b10; elem64 = 0; bcast_en = 0;
    src2_mem = 0; mask_en = 0; zero_mode = 0; sel_imm = 0; mask = 0;
    src1 = '0; src2 = '0; old_dst = '0;
    repeat (3) @(posedge clk);
    #1;
    exp_res = '0;
    chk("R8 reset out_valid", 512'(out_valid), 512'(0));
    chk("R8 reset bad_len", 512'(bad_len), 512'(0));
    chk("R8 reset result", result, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: full-length selection patterns
    op("R1 identity", 2'b10, 0, 0, 0, 0, 0, 8'hE4, 16'h0, A, B, O);
    op("R1 reversed", 2'b10, 0, 0, 0, 0, 0, 8'h1B, 16'h0, A, B, O);
    op("R1 repeat lane", 2'b10, 0, 0, 0, 0, 0, 8'hFF, 16'h0, A, B, O);
    op("R1 mixed", 2'b10, 1, 0, 0, 0, 0, 8'h72, 16'h0, A, B, O);
    // R2/R6: half-length, upper immediate bits set, upper half zero
    op("R2 sel 00", 2'b01, 0, 0, 0, 0, 0, 8'hFC, 16'h0, A, B, O);
    op("R2 sel 11", 2'b01, 0, 0, 0, 0, 0, 8'h03, 16'h0, A, B, O);
    op("R6 upper zero merge", 2'b01, 0, 0, 0, 1, 0, 8'h01, 16'h0, A, B, O);
    // R3: broadcast variants
    op("R3 bcast32", 2'b10, 0, 1, 1, 0, 0, 8'hE4, 16'h0, A, B, O);
    op("R3 bcast64", 2'b10, 1, 1, 1, 0, 0, 8'hB1, 16'h0, A, B, O);
    op("R3 bcast no mem", 2'b10, 0, 1, 0, 0, 0, 8'hE4, 16'h0, A, B, O);
    op("R3 mem no bcast", 2'b10, 0, 0, 1, 0, 0, 8'hE4, 16'h0, A, B, O);
    op("R3 bcast half", 2'b01, 1, 1, 1, 0, 0, 8'h02, 16'h0, A, B, O);
    // R4/R5: masking
    op("R5 merge32", 2'b10, 0, 0, 0, 1, 0, 8'h4E, 16'hA5C3, A, B, O);
    op("R5 zero32", 2'b10, 0, 0, 0, 1, 1, 8'h4E, 16'hA5C3, A, B, O);
    op("R4 merge64", 2'b10, 1, 0, 0, 1, 0, 8'h4E, 16'h0096, A, B, O);
    op("R4 zero64", 2'b10, 1, 0, 0, 1, 1, 8'h4E, 16'h0069, A, B, O);
    op("R5 zero all", 2'b10, 0, 0, 0, 1, 1, 8'hE4, 16'h0000, A, B, O);
    op("R5 unmasked", 2'b10, 0, 0, 0, 0, 1, 8'hE4, 16'h0000, A, B, O);
    // R9: upper mask bits ignored at half length
    op("R9 half32 low", 2'b01, 0, 0, 0, 1, 0, 8'h01, 16'h005A, A, B, O);
    op("R9 half32 junk", 2'b01, 0, 0, 0, 1, 0, 8'h01, 16'hFF5A, A, B, O);
    op("R9 half64 junk", 2'b01, 1, 0, 0, 1, 1, 8'h02, 16'hFFF5, A, B, O);
    // R7: illegal lengths hold result
    op("R7 len 128", 2'b00, 0, 0, 0, 0, 0, 8'h1B, 16'h0, B, A, O);
    op("R7 len rsv", 2'b11, 0, 0, 0, 0, 0, 8'h1B, 16'h0, B, A, O);
    idle("R8");
    op("R8 after idle", 2'b10, 0, 0, 0, 0, 0, 8'h93, 16'h0, B, A, O);
    idle("R8 again");

    for (int n = 0; n < 60; n++) begin
      logic [511:0] ra, rb, ro;
      for (int k = 0; k < 16; k++) begin
        ra[32*k +: 32] = $urandom; rb[32*k +: 32] = $urandom; ro[32*k +: 32] = $urandom;
      end
      op("R1 R5 random", 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), ra, rb, ro);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule